// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block holds the configuration registers that steer four shared PCI interrupt links and the two native-mode IDE channel interrupts onto ISA IRQ numbers. Software writes a 4-bit steering code into a nibble of a routing register. The block turns each code into an IRQ number and a valid flag. Codes are not IRQ numbers: they pass through a fixed lookup that has holes in it. A code of zero or a reserved code disables its line. The interrupt wiring itself, and any conversion from level to edge, are handled elsewhere. The block only stores the registers and decodes the codes.

Access is through a byte-wide port with an 8-bit address, a write strobe and write data. Read data is combinational from the address. One control bit hides the whole upper register space from reads, while writes still take effect. Each IDE channel reports a valid interrupt only when its input strap says the channel runs in native mode.

Top module: `irq_steer_router`

## Requirements
- R1: During and after reset every stored register reads 0x00, and every link and IDE output has valid=0 and IRQ number 0.
- R2: A 4-bit steering code c decodes to an IRQ as follows: 1→9, 2→3, 3→10, 4→4, 5→5, 6→7, 7→6, 8→1, 9→11, 11→12, 13→14, 15→15. The valid flag is 1 for all of these codes.
- R3: Codes 0, 10, 12 and 14 give valid=0 and IRQ number 0.
- R4: Register 0x48 steers link 0 from bits 3:0 and link 1 from bits 7:4. Register 0x49 steers link 2 from bits 3:0 and link 3 from bits 7:4. Link n occupies bits 4n+3:4n of `link_irq` and bit n of `link_valid`.
- R5: Writes store data ANDed with a per-register mask: 0x42 with 0xCF, 0x44 and 0x74 with 0xDF, 0x75, 0x76 and 0x77 with 0x1F, and 0x48 and 0x49 unmasked.
- R6: A write takes effect at the clock edge that samples the strobe. A read in the same cycle returns the old value. Outputs change only after a write edge.
- R7: While bit 7 of register 0x42 is set, a read of any address at or above 0x40 returns 0x00, including 0x42 itself. Writes still update the registers while reads are hidden.
- R8: An address outside {0x42, 0x44, 0x48, 0x49, 0x74, 0x75, 0x76, 0x77} reads 0x00. A write to such an address changes no register and no output.
- R9: The primary IDE interrupt decodes bits 3:0 of 0x44 and the secondary decodes bits 3:0 of 0x75, both with the R2 table. Each is valid only while its native-mode strap input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 8 | Register address for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data |
| ide_pri_native | input | 1 | Primary IDE channel is in native mode |
| ide_sec_native | input | 1 | Secondary IDE channel is in native mode |
| link_irq | output | 16 | Four 4-bit IRQ numbers, link 0 in the low nibble |
| link_valid | output | 4 | Per-link valid flag |
| ide_pri_irq | output | 4 | Primary IDE IRQ number |
| ide_pri_valid | output | 1 | Primary IDE IRQ valid |
| ide_sec_irq | output | 4 | Secondary IDE IRQ number |
| ide_sec_valid | output | 1 | Secondary IDE IRQ valid |

## Verification
Any corrupted register bit appears at the read port in the same cycle as an access to its address, unless the hide bit is set. In the routing registers it also appears on a link or IDE output from the very next clock. The bench therefore compares every output against a behavioural model on every cycle. A bad mask, a wrong decode entry or a misplaced nibble is caught on the first cycle after the write that exposes it. A broken hide or address decode shows up on the read port in the same cycle as the access.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = 4;
  localparam int IRQ_W      = 4;
  localparam int LINK_REGS  = 2;
  localparam int LINKS_PER  = DATA_W / CODE_W;
  localparam int NUM_LINKS  = LINK_REGS * LINKS_PER;
  localparam int NREG       = 8;
  localparam int HIDE_BIT   = 7;

  // register slots
  localparam int IDX_CTRL   = 0;
  localparam int IDX_IDEP   = 1;
  localparam int IDX_LINK0  = 2;
  localparam int IDX_USB    = 4;
  localparam int IDX_IDES   = 5;
  localparam int IDX_PM     = 6;
  localparam int IDX_SMB    = 7;

  localparam logic [ADDR_W-1:0] UPPER_BASE = 8'h40;

  localparam logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {
    8'h77, 8'h76, 8'h75, 8'h74, 8'h49, 8'h48, 8'h44, 8'h42
  };

  localparam logic [NREG-1:0][DATA_W-1:0] REG_MASK = {
    8'h1F, 8'h1F, 8'h1F, 8'hDF, 8'hFF, 8'hFF, 8'hDF, 8'hCF
  };

  typedef struct packed {
    logic [IRQ_W-1:0] irq;
    logic             valid;
  } route_t;

  function automatic route_t code_to_route(input logic [CODE_W-1:0] code);
    route_t r;
    r.valid = 1'b1;
    unique case (code)
      4'd1:    r.irq = 4'd9;
      4'd2:    r.irq = 4'd3;
      4'd3:    r.irq = 4'd10;
      4'd4:    r.irq = 4'd4;
      4'd5:    r.irq = 4'd5;
      4'd6:    r.irq = 4'd7;
      4'd7:    r.irq = 4'd6;
      4'd8:    r.irq = 4'd1;
      4'd9:    r.irq = 4'd11;
      4'd11:   r.irq = 4'd12;
      4'd13:   r.irq = 4'd14;
      4'd15:   r.irq = 4'd15;
      default: begin
        r.irq   = '0;
        r.valid = 1'b0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   regs_q
);

  logic [NREG-1:0][DATA_W-1:0] regs_d;
  logic [NREG-1:0]             sel;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign sel[i] = wr && (addr == REG_ADDR[i]);

    always_comb begin
      regs_d[i] = regs_q[i];
      if (sel[i]) regs_d[i] = wdata & REG_MASK[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= regs_d[i];
    end
  end

endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic [IRQ_W-1:0]  irq,
  output logic              valid
);

  route_t route;

  always_comb begin
    route = code_to_route(code);
    valid = enable && route.valid;
    irq   = valid ? route.irq : '0;
  end

endmodule

// File: rtl/irq_steer_rdmux.sv
module irq_steer_rdmux
  import irq_steer_pkg::*;
(
  input  logic [NREG-1:0][DATA_W-1:0] regs_q,
  input  logic [ADDR_W-1:0]           addr,
  output logic [DATA_W-1:0]           rdata
);

  logic hide;
  logic blocked;

  always_comb begin
    hide    = regs_q[IDX_CTRL][HIDE_BIT];
    blocked = hide && (addr >= UPPER_BASE);
    rdata   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (!blocked && (addr == REG_ADDR[i])) rdata = regs_q[i];
    end
  end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  input  logic                          ide_pri_native,
  input  logic                          ide_sec_native,
  output logic [NUM_LINKS*IRQ_W-1:0]    link_irq,
  output logic [NUM_LINKS-1:0]          link_valid,
  output logic [IRQ_W-1:0]              ide_pri_irq,
  output logic                          ide_pri_valid,
  output logic [IRQ_W-1:0]              ide_sec_irq,
  output logic                          ide_sec_valid
);

  logic [NREG-1:0][DATA_W-1:0] regs_q;

  irq_steer_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .regs_q (regs_q)
  );

  irq_steer_rdmux u_rdmux (
    .regs_q (regs_q),
    .addr   (cfg_addr),
    .rdata  (cfg_rdata)
  );

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    localparam int RIDX = IDX_LINK0 + (l / LINKS_PER);
    localparam int LSB  = CODE_W * (l % LINKS_PER);
    irq_steer_decode u_dec (
      .code   (regs_q[RIDX][LSB +: CODE_W]),
      .enable (1'b1),
      .irq    (link_irq[l*IRQ_W +: IRQ_W]),
      .valid  (link_valid[l])
    );
  end

  irq_steer_decode u_dec_pri (
    .code   (regs_q[IDX_IDEP][CODE_W-1:0]),
    .enable (ide_pri_native),
    .irq    (ide_pri_irq),
    .valid  (ide_pri_valid)
  );

  irq_steer_decode u_dec_sec (
    .code   (regs_q[IDX_IDES][CODE_W-1:0]),
    .enable (ide_sec_native),
    .irq    (ide_sec_irq),
    .valid  (ide_sec_valid)
  );

endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk
  import irq_steer_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_wr,
  input logic [ADDR_W-1:0]          cfg_addr,
  input logic [DATA_W-1:0]          cfg_wdata,
  input logic [DATA_W-1:0]          cfg_rdata,
  input logic                       ide_pri_native,
  input logic                       ide_sec_native,
  input logic [NUM_LINKS*IRQ_W-1:0] link_irq,
  input logic [NUM_LINKS-1:0]       link_valid,
  input logic [IRQ_W-1:0]           ide_pri_irq,
  input logic                       ide_pri_valid,
  input logic [IRQ_W-1:0]           ide_sec_irq,
  input logic                       ide_sec_valid
);

  logic mapped;
  assign mapped = cfg_addr inside {8'h42, 8'h44, 8'h48, 8'h49,
                                   8'h74, 8'h75, 8'h76, 8'h77};

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_rst_quiet_R1: assert (link_valid == '0 && !ide_pri_valid && !ide_sec_valid);
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(link_irq) && $stable(link_valid)));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (cfg_rdata == '0));

  assert_hide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'h42 && cfg_wdata[7])
      |=> ((cfg_addr >= 8'h40) -> (cfg_rdata == '0)));

  assert_pri_strap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_pri_native |-> (!ide_pri_valid && ide_pri_irq == '0));

  assert_sec_strap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_sec_native |-> (!ide_sec_valid && ide_sec_irq == '0));

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lchk
    assert_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !link_valid[l] |-> (link_irq[l*IRQ_W +: IRQ_W] == '0));
    assert_legal_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid[l] |-> !(link_irq[l*IRQ_W +: IRQ_W] inside {4'd0, 4'd2, 4'd8, 4'd13}));
  end

endmodule

bind irq_steer_router irq_steer_router_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr         (cfg_wr),
  .cfg_addr       (cfg_addr),
  .cfg_wdata      (cfg_wdata),
  .cfg_rdata      (cfg_rdata),
  .ide_pri_native (ide_pri_native),
  .ide_sec_native (ide_sec_native),
  .link_irq       (link_irq),
  .link_valid     (link_valid),
  .ide_pri_irq    (ide_pri_irq),
  .ide_pri_valid  (ide_pri_valid),
  .ide_sec_irq    (ide_sec_irq),
  .ide_sec_valid  (ide_sec_valid)
);

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        ide_pri_native = 1'b0;
  logic        ide_sec_native = 1'b0;
  logic [15:0] link_irq;
  logic [3:0]  link_valid;
  logic [3:0]  ide_pri_irq;
  logic        ide_pri_valid;
  logic [3:0]  ide_sec_irq;
  logic        ide_sec_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [7:0] mreg [256];
  int irq_of [16] = '{0, 9, 3, 10, 4, 5, 7, 6, 1, 11, 0, 12, 0, 14, 0, 15};

  always #2.5 clk = ~clk;

  irq_steer_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ide_pri_native(ide_pri_native), .ide_sec_native(ide_sec_native),
    .link_irq(link_irq), .link_valid(link_valid),
    .ide_pri_irq(ide_pri_irq), .ide_pri_valid(ide_pri_valid),
    .ide_sec_irq(ide_sec_irq), .ide_sec_valid(ide_sec_valid)
  );

  function automatic int mask_of(input logic [7:0] a);
    case (a)
      8'h42:                return 'hCF;
      8'h44, 8'h74:         return 'hDF;
      8'h75, 8'h76, 8'h77:  return 'h1F;
      8'h48, 8'h49:         return 'hFF;
      default:              return -1;
    endcase
  endfunction

  function automatic logic [7:0] ref_read(input logic [7:0] a);
    if (mask_of(a) < 0) return 8'h00;
    if (mreg[8'h42][7] && a >= 8'h40) return 8'h00;
    return mreg[a];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] exp_rd;
    exp_rd = ref_read(cfg_addr);
    check(cfg_rdata == exp_rd, tag, cfg_rdata, exp_rd);
    for (int l = 0; l < 4; l++) begin
      int code;
      int e_irq;
      code  = (l < 2) ? int'((mreg[8'h48] >> (4*l)) & 8'hF)
                      : int'((mreg[8'h49] >> (4*(l-2))) & 8'hF);
      e_irq = irq_of[code];
      check(int'(link_irq[l*4 +: 4]) == e_irq && link_valid[l] == (e_irq != 0),
            "R4 link", {link_valid[l], link_irq[l*4 +: 4]}, {e_irq != 0, 4'(e_irq)});
    end
    begin
      int ep;
      int es;
      ep = ide_pri_native ? irq_of[mreg[8'h44][3:0]] : 0;
      es = ide_sec_native ? irq_of[mreg[8'h75][3:0]] : 0;
      check(int'(ide_pri_irq) == ep && ide_pri_valid == (ep != 0), "R9 primary",
            {ide_pri_valid, ide_pri_irq}, {ep != 0, 4'(ep)});
      check(int'(ide_sec_irq) == es && ide_sec_valid == (es != 0), "R9 secondary",
            {ide_sec_valid, ide_sec_irq}, {es != 0, 4'(es)});
    end
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    cfg_wr = w; cfg_addr = a; cfg_wdata = d;
    #1;
    compare_all(tag);
    @(posedge clk);
    if (w && mask_of(a) >= 0) mreg[a] = d & 8'(mask_of(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] lfsr;
    logic [7:0] maps [8] = '{8'h42, 8'h44, 8'h48, 8'h49, 8'h74, 8'h75, 8'h76, 8'h77};
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;

    // R1: reset state, observed while reset is held and after release
    repeat (3) @(negedge clk);
    #1;
    check(link_valid == 4'h0 && link_irq == 16'h0, "R1 in reset", {link_valid, link_irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b0, maps[i], 8'h00, "R1 read");

    // R2 / R3: every code on links 0 and 1
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 8'h48, 8'((c << 4) | c), "R2 write");
      step(1'b0, 8'h48, 8'h00, (irq_of[c] != 0) ? "R2 decode" : "R3 disabled code");
    end

    // R4: distinct codes in each nibble
    step(1'b1, 8'h48, 8'h21, "R4 lo");
    step(1'b1, 8'h49, 8'h43, "R4 hi");
    step(1'b0, 8'h49, 8'h00, "R4 readback");

    // R5: write all-ones, read the masked result
    foreach (maps[i]) if (maps[i] != 8'h42) step(1'b1, maps[i], 8'hFF, "R5 write");
    step(1'b1, 8'h42, 8'h7F, "R5 ctrl");
    foreach (maps[i]) step(1'b0, maps[i], 8'h00, "R5 mask");

    // R6: write and read the same register in one cycle
    step(1'b1, 8'h49, 8'h95, "R6 old value");
    step(1'b0, 8'h49, 8'h00, "R6 new value");

    // R9: straps gate the IDE outputs
    step(1'b1, 8'h44, 8'h05, "R9 pri code");
    step(1'b1, 8'h75, 8'h0D, "R9 sec code");
    step(1'b0, 8'h00, 8'h00, "R9 straps low");
    ide_pri_native = 1'b1;
    step(1'b0, 8'h00, 8'h00, "R9 pri native");
    ide_sec_native = 1'b1;
    step(1'b0, 8'h00, 8'h00, "R9 both native");
    step(1'b1, 8'h75, 8'h0E, "R9 reserved sec");
    step(1'b0, 8'h75, 8'h00, "R9 reserved sec out");

    // R7: hide upper space, writes still land
    step(1'b1, 8'h42, 8'h80, "R7 set hide");
    foreach (maps[i]) step(1'b0, maps[i], 8'h00, "R7 hidden");
    step(1'b1, 8'h48, 8'h3B, "R7 write while hidden");
    step(1'b1, 8'h42, 8'h00, "R7 clear hide");
    step(1'b0, 8'h48, 8'h00, "R7 visible again");

    // R8: unmapped addresses
    step(1'b1, 8'h43, 8'hFF, "R8 write 43");
    step(1'b1, 8'h4A, 8'hFF, "R8 write 4A");
    step(1'b1, 8'h10, 8'hFF, "R8 write 10");
    step(1'b0, 8'h43, 8'h00, "R8 read 43");
    step(1'b0, 8'h10, 8'h00, "R8 read 10");
    foreach (maps[i]) if (maps[i] != 8'h42) step(1'b0, maps[i], 8'h00, "R8 untouched");

    // mixed traffic
    lfsr = 8'hA5;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ide_pri_native = lfsr[1];
      ide_sec_native = lfsr[6];
      step(lfsr[0], (lfsr[2] ? maps[lfsr[5:3]] : lfsr), {lfsr[3:0], lfsr[7:4]}, "R6 mixed");
    end

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    foreach (maps[i]) step(1'b0, maps[i], 8'h00, "R1 after reset");

    finish_run();
  end

endmodule